// File: doc/BRIEF.md
# Matrix Element Index Remapper

This block produces the element index for each step of a vector loop. The element sequence is treated as a three-dimensional array with axes x, y and z. Software chooses the extent of each axis, which axis is walked innermost, middle and outermost, and whether each axis runs upward or downward. A fixed offset is added to every result. The block does not touch any register file. It only produces the index stream that a datapath uses to address its operands.

A one-cycle `start` pulse captures the whole configuration and sets every axis counter to its first value. From then on the block presents one index at a time on a valid/ready output. Whenever `out_valid` is high and `out_ready` is low, the presented index and its end flag are held unchanged. A beat is consumed on a clock edge where both signals are high. The beat that carries element `len_m1` is marked with `out_last`. Once that beat is consumed, the stream goes idle until the next `start`. A `start` that arrives while a sequence is running abandons that sequence and begins a new one.

Top module: `mxr_remap`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low until a `start` is seen.
- R2: The clock edge that samples `start` high loads the configuration. From the next cycle, `out_valid` is high and `out_index` carries element 0. The first coordinate of each axis is 0, or its size field if that axis is inverted.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_index` and `out_last` do not change.
- R4: Each size field holds the axis length minus one. The array index is x + y*(xsz+1) + z*(xsz+1)*(ysz+1). With permute code 3'b000, x steps fastest, then y, then z.
- R5: The other permute codes give these orders, innermost first: 3'b001 is x,z,y; 3'b010 is y,x,z; 3'b011 is y,z,x; 3'b100 is z,x,y; 3'b101 is z,y,x. The index formula of R4 is unchanged.
- R6: Permute codes 3'b110 and 3'b111 give the same sequence as 3'b000.
- R7: Invert bit 0 applies to x, bit 1 to y and bit 2 to z. An inverted axis counts from its size field down to 0, then restarts at its size field.
- R8: `offset` is added to every index, modulo 2^OUTW.
- R9: `out_last` is high exactly on the beat of element `len_m1`. After that beat is consumed, `out_valid` goes low.
- R10: A size field of zero keeps that axis at coordinate 0, so the axis has no effect on the sequence.
- R11: Configuration inputs, including the skip bits, have no effect on a running sequence. The skip bits have no effect at any time.
- R12: If `len_m1` is larger than the number of array elements minus one, the sequence restarts at element 0 of the array and continues.
- R13: A `start` while a sequence is active restarts from element 0 with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin a sequence |
| len_m1 | input | LENW | Number of elements minus one |
| xsz | input | DIMW | X length minus one |
| ysz | input | DIMW | Y length minus one |
| zsz | input | DIMW | Z length minus one |
| perm | input | 3 | Axis nesting order code |
| inv | input | 3 | Per-axis downward count (bit 0 x, 1 y, 2 z) |
| skip | input | 2 | Accepted and ignored |
| offset | input | OUTW | Added to every index |
| out_valid | output | 1 | Index beat present |
| out_ready | input | 1 | Consumer accepts beat |
| out_index | output | OUTW | Remapped index plus offset |
| out_last | output | 1 | Beat carries element len_m1 |

## Verification
Element 0 appears one cycle after the edge that samples `start`. Each later element appears one cycle after the edge that consumes the previous beat. The bench drives inputs on falling edges and compares outputs on the following falling edge, which lands after each of those single-register updates. During stalls it re-reads the held beat on every falling edge. After the last beat is consumed, it looks for `out_valid` low on the next falling edge.

// File: rtl/mxr_pkg.sv
package mxr_pkg;
  localparam int AXES = 3;

  // Axis identifiers: x = 0, y = 1, z = 2.
  // The result is packed {outer, middle, inner}, two bits per level.
  function automatic logic [5:0] order_axes(input logic [2:0] code);
    case (code)
      3'b001:  return {2'd1, 2'd2, 2'd0}; // x, z, y
      3'b010:  return {2'd2, 2'd0, 2'd1}; // y, x, z
      3'b011:  return {2'd0, 2'd2, 2'd1}; // y, z, x
      3'b100:  return {2'd1, 2'd0, 2'd2}; // z, x, y
      3'b101:  return {2'd0, 2'd1, 2'd2}; // z, y, x
      default: return {2'd2, 2'd1, 2'd0}; // x, y, z (also 110, 111)
    endcase
  endfunction
endpackage

// File: rtl/mxr_axis.sv
module mxr_axis #(
  parameter int DIMW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [DIMW-1:0] size_i,
  input  logic            inv_i,
  output logic [DIMW-1:0] coord_n,
  output logic [DIMW-1:0] size_n,
  output logic            at_end
);
  logic [DIMW-1:0] coord_q, size_q;
  logic            inv_q, inv_n;

  assign at_end = inv_q ? (coord_q == '0) : (coord_q == size_q);

  always_comb begin
    coord_n = coord_q;
    size_n  = size_q;
    inv_n   = inv_q;
    if (load) begin
      size_n  = size_i;
      inv_n   = inv_i;
      coord_n = inv_i ? size_i : '0;
    end else if (step) begin
      if (at_end)     coord_n = inv_q ? size_q : '0;
      else if (inv_q) coord_n = coord_q - 1'b1;
      else            coord_n = coord_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coord_q <= '0;
      size_q  <= '0;
      inv_q   <= 1'b0;
    end else begin
      coord_q <= coord_n;
      size_q  <= size_n;
      inv_q   <= inv_n;
    end
  end
endmodule

// File: rtl/mxr_index.sv
module mxr_index #(
  parameter int DIMW = 4,
  parameter int OUTW = 13
) (
  input  logic [DIMW-1:0] cx,
  input  logic [DIMW-1:0] cy,
  input  logic [DIMW-1:0] cz,
  input  logic [DIMW-1:0] xs,
  input  logic [DIMW-1:0] ys,
  input  logic [OUTW-1:0] off,
  output logic [OUTW-1:0] idx
);
  logic [OUTW-1:0] xlen, ylen, plane;

  always_comb begin
    xlen  = OUTW'(xs) + 1'b1;
    ylen  = OUTW'(ys) + 1'b1;
    plane = xlen * ylen;
    idx   = OUTW'(cx) + OUTW'(cy) * xlen + OUTW'(cz) * plane + off;
  end
endmodule

// File: rtl/mxr_remap.sv
module mxr_remap #(
  parameter int DIMW = 4,
  parameter int LENW = 8,
  parameter int OUTW = 3 * DIMW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LENW-1:0] len_m1,
  input  logic [DIMW-1:0] xsz,
  input  logic [DIMW-1:0] ysz,
  input  logic [DIMW-1:0] zsz,
  input  logic [2:0]      perm,
  input  logic [2:0]      inv,
  input  logic [1:0]      skip,
  input  logic [OUTW-1:0] offset,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUTW-1:0] out_index,
  output logic            out_last
);
  import mxr_pkg::*;

  logic                       active_q, last_q;
  logic [LENW-1:0]            cnt_q, len_q, cnt_n, len_n;
  logic [2:0]                 perm_q;
  logic [OUTW-1:0]            off_q, off_n, idx_q, idx_n;
  logic [AXES-1:0][DIMW-1:0]  size_in, crd_n, sz_n;
  logic [AXES-1:0]            at_end, ax_step;
  logic [2:0]                 lvl_end, step_lvl;
  logic [5:0]                 ord;
  logic                       hs, adv;
  logic                       skip_unused;

  assign skip_unused = ^skip;
  assign size_in     = {zsz, ysz, xsz};
  assign hs          = active_q & out_ready;
  assign adv         = hs & ~last_q & ~start;

  always_comb begin
    ord      = order_axes(perm_q);
    lvl_end  = '0;
    for (int l = 0; l < 3; l++) lvl_end[l] = at_end[ord[2*l +: 2]];
    step_lvl = {adv & lvl_end[0] & lvl_end[1], adv & lvl_end[0], adv};
    ax_step  = '0;
    for (int l = 0; l < 3; l++)
      for (int a = 0; a < AXES; a++)
        if (ord[2*l +: 2] == 2'(a)) ax_step[a] = step_lvl[l];
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    mxr_axis #(.DIMW(DIMW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .step   (ax_step[a]),
      .size_i (size_in[a]),
      .inv_i  (inv[a]),
      .coord_n(crd_n[a]),
      .size_n (sz_n[a]),
      .at_end (at_end[a])
    );
  end

  assign off_n = start ? offset : off_q;

  mxr_index #(.DIMW(DIMW), .OUTW(OUTW)) u_index (
    .cx (crd_n[0]),
    .cy (crd_n[1]),
    .cz (crd_n[2]),
    .xs (sz_n[0]),
    .ys (sz_n[1]),
    .off(off_n),
    .idx(idx_n)
  );

  always_comb begin
    len_n = start ? len_m1 : len_q;
    cnt_n = start ? '0 : (adv ? cnt_q + 1'b1 : cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      perm_q   <= '0;
      off_q    <= '0;
      idx_q    <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        perm_q   <= perm;
      end else if (hs && last_q) begin
        active_q <= 1'b0;
      end
      if (start || adv) begin
        idx_q  <= idx_n;
        last_q <= (cnt_n == len_n);
      end
      cnt_q <= cnt_n;
      len_q <= len_n;
      off_q <= off_n;
    end
  end

  assign out_valid = active_q;
  assign out_index = idx_q;
  assign out_last  = active_q & last_q;
endmodule

// File: rtl/mxr_check.sv
module mxr_check #(
  parameter int OUTW = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_last,
  input logic [OUTW-1:0] out_index
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_last));

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_index) && $stable(out_last)));

  assert_last_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !start) |=> !out_valid);
endmodule

bind mxr_remap mxr_check #(.OUTW(OUTW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_last (out_last),
  .out_index(out_index)
);

// File: tb/sim_mxr_remap.sv
module sim_mxr_remap;
  localparam int DIMW = 4;
  localparam int LENW = 8;
  localparam int OUTW = 3 * DIMW + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [LENW-1:0] len_m1 = '0;
  logic [DIMW-1:0] xsz = '0, ysz = '0, zsz = '0;
  logic [2:0] perm = '0, inv = '0;
  logic [1:0] skip = '0;
  logic [OUTW-1:0] offset = '0;
  logic out_valid, out_last;
  logic [OUTW-1:0] out_index;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int c_x, c_y, c_z, c_perm, c_inv, c_off, c_len;

  always #4 clk = ~clk;

  mxr_remap #(.DIMW(DIMW), .LENW(LENW), .OUTW(OUTW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(len_m1),
    .xsz(xsz), .ysz(ysz), .zsz(zsz), .perm(perm), .inv(inv), .skip(skip),
    .offset(offset), .out_valid(out_valid), .out_ready(out_ready),
    .out_index(out_index), .out_last(out_last)
  );

  function automatic int model(input int e);
    int len[3], sz[3], crd[3], ord[3], n, i, d0, d1, d2;
    sz[0] = c_x; sz[1] = c_y; sz[2] = c_z;
    for (int a = 0; a < 3; a++) len[a] = sz[a] + 1;
    case (c_perm)
      1: ord = '{0, 2, 1};
      2: ord = '{1, 0, 2};
      3: ord = '{1, 2, 0};
      4: ord = '{2, 0, 1};
      5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    n  = len[0] * len[1] * len[2];
    i  = e % n;
    d0 = i % len[ord[0]];
    d1 = (i / len[ord[0]]) % len[ord[1]];
    d2 = i / (len[ord[0]] * len[ord[1]]);
    crd[ord[0]] = d0; crd[ord[1]] = d1; crd[ord[2]] = d2;
    for (int a = 0; a < 3; a++)
      if (c_inv[a]) crd[a] = sz[a] - crd[a];
    return (crd[0] + crd[1] * len[0] + crd[2] * len[0] * len[1] + c_off)
           & ((1 << OUTW) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    xsz = DIMW'(c_x); ysz = DIMW'(c_y); zsz = DIMW'(c_z);
    perm = 3'(c_perm); inv = 3'(c_inv); offset = OUTW'(c_off);
    len_m1 = LENW'(c_len); out_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Element e is expected on the current falling edge; consume it.
  task automatic take(input int e, input string req);
    int exp;
    exp = model(e);
    check(out_valid === 1'b1, (e == 0) ? "R2" : req, int'(out_valid), 1);
    check(out_index == OUTW'(exp), (e == 0) ? "R2" : req, int'(out_index), exp);
    check(out_last == (e == c_len), "R9", int'(out_last), int'(e == c_len));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_full(input string req);
    pulse_start();
    for (int e = 0; e <= c_len; e++) take(e, req);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", int'(out_last), 0);
  endtask

  task automatic t_orders();
    c_x = 2; c_y = 1; c_z = 2; c_off = 5;
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 8; v++) begin
        c_perm = p; c_inv = v; c_len = 17;
        if (v != 0)      run_full("R7");
        else if (p == 0) run_full("R4");
        else if (p < 6)  run_full("R5");
        else             run_full("R6");
      end
  endtask

  task automatic t_zero_dims();
    c_x = 3; c_y = 0; c_z = 0; c_perm = 4; c_inv = 0; c_off = 0; c_len = 3;
    run_full("R10");
    c_x = 0; c_y = 2; c_z = 0; c_perm = 0; c_inv = 3'b101; c_len = 2;
    run_full("R10");
    c_x = 0; c_y = 0; c_z = 0; c_perm = 5; c_inv = 7; c_len = 0;
    run_full("R10");
  endtask

  task automatic t_offset();
    c_x = 1; c_y = 1; c_z = 1; c_perm = 3; c_inv = 2; c_len = 7;
    c_off = (1 << OUTW) - 3;
    run_full("R8");
  endtask

  task automatic t_stall();
    c_x = 2; c_y = 2; c_z = 0; c_perm = 2; c_inv = 1; c_off = 1; c_len = 8;
    pulse_start();
    for (int e = 0; e <= c_len; e++) begin
      if (e == 0 || e == 4 || e == c_len)
        for (int k = 0; k < 3; k++) begin
          check(out_valid == 1'b1, "R3", int'(out_valid), 1);
          check(out_index == OUTW'(model(e)), "R3", int'(out_index), model(e));
          check(out_last == (e == c_len), "R3", int'(out_last), int'(e == c_len));
          @(negedge clk);
        end
      take(e, "R3");
    end
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
  endtask

  task automatic t_cfg_hold();
    c_x = 1; c_y = 2; c_z = 1; c_perm = 1; c_inv = 4; c_off = 9; c_len = 11;
    pulse_start();
    xsz = 4'd3; ysz = 4'd0; zsz = 4'd2; perm = 3'd5; inv = 3'd3;
    offset = OUTW'(100); len_m1 = LENW'(2); skip = 2'b11;
    for (int e = 0; e <= c_len; e++) take(e, "R11");
    check(out_valid == 1'b0, "R11", int'(out_valid), 0);
    skip = 2'b10;
    run_full("R11");
    skip = 2'b00;
  endtask

  task automatic t_wrap();
    c_x = 1; c_y = 0; c_z = 2; c_perm = 4; c_inv = 1; c_off = 0; c_len = 13;
    run_full("R12");
  endtask

  task automatic t_restart();
    c_x = 2; c_y = 2; c_z = 2; c_perm = 0; c_inv = 0; c_off = 0; c_len = 26;
    pulse_start();
    for (int e = 0; e < 3; e++) take(e, "R13");
    c_x = 1; c_y = 3; c_z = 0; c_perm = 3; c_inv = 6; c_off = 40; c_len = 7;
    pulse_start();
    for (int e = 0; e <= c_len; e++) take(e, "R13");
    check(out_valid == 1'b0, "R13", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_orders();
    t_zero_dims();
    t_offset();
    t_stall();
    t_cfg_hold();
    t_wrap();
    t_restart();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule